// File: doc/BRIEF.md
# Memory Bus Bandwidth Monitor

This block watches the traffic that several masters move across a shared memory interconnect and reports it to software. Each master has a tap made of a beat-valid bit and a byte count. On every cycle in which the monitor is enabled and a tap's valid bit is high, that tap's byte count is added to a running counter for that master. A programmable prescaler divides the bus clock into ticks. Programming it with the bus frequency in MHz minus one makes each tick one microsecond long. A measurement window lasts a programmable number of ticks. When a window closes, the total traffic of that window across all masters is compared with the largest window total seen so far, and the larger value is kept. The total register therefore reports the busiest single window, not a cumulative sum.

Software sets the prescaler and a configuration word through a plain write port, and reads every register through a combinational read port. The configuration word holds the window length, a reporting unit and an enable bit. All counting state is cleared only when the enable bit goes from 0 to 1. The taps are observation-only, so they carry no ready signal. The monitor never back-pressures the bus, and a beat counts whenever its valid bit is high while the monitor is enabled.

Top module: `bwmon_top`

## Requirements
- R1: After reset, the prescaler register, the configuration word, every per-master counter and the total register all read 0, and the monitor is disabled.
- R2: While the monitor is enabled, a tick occurs every (prescaler + 1) cycles. A window is (cfg[31:16] + 1) ticks long. Both counters restart when the monitor is enabled.
- R3: Per-master counter i, read at byte address 0xA0 + 4*i, holds the running sum of the byte counts on every enabled cycle in which tap i's valid bit was high.
- R4: The total register, read at 0xB4 (slot 5 of the counter array), holds the largest all-master byte total of any single closed window since the last clear. Beats sampled in the cycle that closes a window count toward that window.
- R5: The window accumulator restarts from zero after each window boundary, so a burst that spans a boundary is split between the two windows.
- R6: The unit field cfg[2:1] selects the reporting unit: 0 = bytes, 1 = KiB, 2 = MiB (3 reads as bytes). A read returns the full byte count shifted right by 0, 10 or 20 bits, so fractional units keep accumulating and are never discarded.
- R7: A write that takes cfg[0] from 0 to 1 clears all counters, the window accumulator and the total register. A configuration write that leaves cfg[0] at 1 clears nothing.
- R8: While cfg[0] is 0, beats are ignored and all counters and the total register hold their values.
- R9: Every counter saturates at all ones of its CNT_W bits and never wraps.
- R10: The prescaler (byte address 0x00) and the configuration word (0x04) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | NUM_MASTERS | One valid bit per master tap |
| beat_bytes | input | NUM_MASTERS*BYTES_W | Byte count per master tap; master i occupies bits [i*BYTES_W +: BYTES_W] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Combinational read data; unmapped addresses read 0 |

## Verification
Every counting register is visible only through the read port, so a fault in the internal state shows up the next time that register is read. A prescaler or window counter that is off by one changes where the window boundaries fall. The bench detects this by driving a burst that deliberately spans a boundary: a wrong boundary changes the peak value read back once that window closes. A peak register that sums instead of taking the maximum, a clear that fires on every write, or a unit shift that truncates on each window would all produce a wrong read within a few dozen cycles of the stimulus that exposes them.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

  // Register byte offsets; counter slots sit at CTR_BASE + 4*slot.
  localparam int unsigned PRESC_OFS  = 'h000;
  localparam int unsigned CFG_OFS    = 'h004;
  localparam int unsigned CTR_BASE   = 'h0A0;
  localparam int unsigned TOTAL_SLOT = 5;

  typedef enum logic [1:0] {
    UNIT_BYTE = 2'd0,
    UNIT_KIB  = 2'd1,
    UNIT_MIB  = 2'd2,
    UNIT_RSVD = 2'd3
  } unit_e;

  typedef struct packed {
    logic [15:0] period_m1;
    logic [12:0] spare;
    unit_e       unit;
    logic        en;
  } cfg_t;

  function automatic int unsigned unit_shift(input unit_e u);
    case (u)
      UNIT_KIB: return 10;
      UNIT_MIB: return 20;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/bwmon_tick_gen.sv
module bwmon_tick_gen #(
  parameter int PRESC_W = 32,
  parameter int WIN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic [PRESC_W-1:0] presc_m1,
  input  logic [WIN_W-1:0]   period_m1,
  output logic               tick,
  output logic               win_end
);
  logic [PRESC_W-1:0] pre_q;
  logic [WIN_W-1:0]   win_q;
  logic               pre_wrap;

  // >= keeps a shrinking limit from letting the counter run away
  assign pre_wrap = pre_q >= presc_m1;
  assign tick     = en && pre_wrap;
  assign win_end  = tick && (win_q >= period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (en) begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (tick) win_q <= win_end ? '0 : win_q + 1'b1;
    end
  end
endmodule

// File: rtl/bwmon_sat_ctr.sv
module bwmon_sat_ctr #(
  parameter int CNT_W = 32,
  parameter int IN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             inc_valid,
  input  logic [IN_W-1:0]  inc_amt,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W:0] ext_sum;

  assign ext_sum = {1'b0, count} + (CNT_W+1)'(inc_amt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (en && inc_valid)  count <= ext_sum[CNT_W] ? '1 : ext_sum[CNT_W-1:0];
  end
endmodule

// File: rtl/bwmon_win_peak.sv
module bwmon_win_peak #(
  parameter int CNT_W = 32,
  parameter int SUM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             win_end,
  input  logic [SUM_W-1:0] beat_sum,
  output logic [CNT_W-1:0] peak
);
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_next;
  logic [CNT_W:0]   ext_sum;

  // Window total including this cycle's beats, saturated
  assign ext_sum  = {1'b0, acc_q} + (CNT_W+1)'(beat_sum);
  assign acc_next = ext_sum[CNT_W] ? '1 : ext_sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      peak  <= '0;
    end else if (clr) begin
      acc_q <= '0;
      peak  <= '0;
    end else if (en) begin
      if (win_end) begin
        acc_q <= '0;
        if (acc_next > peak) peak <= acc_next;
      end else begin
        acc_q <= acc_next;
      end
    end
  end
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
  import bwmon_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int BYTES_W     = 8,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS-1:0]         beat_valid,
  input  logic [NUM_MASTERS*BYTES_W-1:0] beat_bytes,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [31:0]                    rd_data
);
  localparam int SUM_W  = BYTES_W + $clog2(NUM_MASTERS + 1);
  localparam int SLOT_W = ADDR_W - 2;

  logic [31:0]                  presc_q;
  cfg_t                         cfg_q;
  logic                         en_q;
  logic                         cfg_wr;
  logic                         clr_pulse;
  logic                         tick;
  logic                         win_end;
  logic [SUM_W-1:0]             beat_sum;
  logic [CNT_W-1:0]             peak_q;
  logic [NUM_MASTERS*CNT_W-1:0] cnt_flat;
  logic [ADDR_W-1:0]            rd_off;
  logic [SLOT_W-1:0]            rd_slot;

  assign cfg_wr    = wr_en && (wr_addr == ADDR_W'(CFG_OFS));
  assign en_q      = cfg_q.en;
  // Clear lands on the same edge that sets the enable bit
  assign clr_pulse = cfg_wr && wr_data[0] && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cfg_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(PRESC_OFS)) presc_q <= wr_data;
      if (cfg_wr)                        cfg_q   <= cfg_t'(wr_data);
    end
  end

  bwmon_tick_gen #(.PRESC_W(32), .WIN_W(16)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .clr       (clr_pulse),
    .presc_m1  (presc_q),
    .period_m1 (cfg_q.period_m1),
    .tick      (tick),
    .win_end   (win_end)
  );

  always_comb begin
    beat_sum = '0;
    for (int i = 0; i < NUM_MASTERS; i++)
      if (beat_valid[i]) beat_sum = beat_sum + SUM_W'(beat_bytes[i*BYTES_W +: BYTES_W]);
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_ctr
    bwmon_sat_ctr #(.CNT_W(CNT_W), .IN_W(BYTES_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_pulse),
      .en        (en_q),
      .inc_valid (beat_valid[g]),
      .inc_amt   (beat_bytes[g*BYTES_W +: BYTES_W]),
      .count     (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  bwmon_win_peak #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_pulse),
    .en       (en_q),
    .win_end  (win_end),
    .beat_sum (beat_sum),
    .peak     (peak_q)
  );

  function automatic logic [31:0] to_units(input logic [CNT_W-1:0] v, input unit_e u);
    logic [CNT_W-1:0] shifted;
    shifted = v >> unit_shift(u);
    return 32'(shifted);
  endfunction

  assign rd_off  = rd_addr - ADDR_W'(CTR_BASE);
  assign rd_slot = rd_off[ADDR_W-1:2];

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(PRESC_OFS)) begin
      rd_data = presc_q;
    end else if (rd_addr == ADDR_W'(CFG_OFS)) begin
      rd_data = cfg_q;
    end else if (rd_addr >= ADDR_W'(CTR_BASE) && rd_off[1:0] == 2'b00) begin
      if (rd_slot == SLOT_W'(TOTAL_SLOT)) begin
        rd_data = to_units(peak_q, cfg_q.unit);
      end else begin
        for (int i = 0; i < NUM_MASTERS; i++)
          if (rd_slot == SLOT_W'(i)) rd_data = to_units(cnt_flat[i*CNT_W +: CNT_W], cfg_q.unit);
      end
    end
  end
endmodule

// File: rtl/bwmon_checker.sv
module bwmon_checker #(
  parameter int NUM_MASTERS = 4,
  parameter int CNT_W       = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           en_q,
  input logic                           clr_pulse,
  input logic                           tick,
  input logic                           win_end,
  input logic [CNT_W-1:0]               peak_q,
  input logic [NUM_MASTERS*CNT_W-1:0]   cnt_flat
);
  AST_TICK_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en_q); // R2
  AST_WINDOW_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> tick); // R2
  AST_PEAK_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> peak_q >= $past(peak_q)); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (peak_q == '0 && cnt_flat == '0)); // R7
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_pulse) |=> ($stable(cnt_flat) && $stable(peak_q))); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_flat[CNT_W-1:0] == {CNT_W{1'b1}} && !clr_pulse) |=> cnt_flat[CNT_W-1:0] == {CNT_W{1'b1}}); // R9
endmodule

bind bwmon_top bwmon_checker #(.NUM_MASTERS(NUM_MASTERS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .clr_pulse (clr_pulse),
  .tick      (tick),
  .win_end   (win_end),
  .peak_q    (peak_q),
  .cnt_flat  (cnt_flat)
);

// File: tb/tb_bwmon_top.sv
`timescale 1ns/1ps
module tb_bwmon_top;
  localparam int NM = 4;
  localparam int BW = 8;
  localparam int CW = 21;
  localparam int AW = 12;
  localparam logic [31:0] SAT = 32'h001F_FFFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NM-1:0]   beat_valid = '0;
  logic [NM*BW-1:0] beat_bytes = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [31:0]     rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_busy = 1'b0;
  bit done     = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   exp;
    string         tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  bwmon_top #(.NUM_MASTERS(NM), .BYTES_W(BW), .CNT_W(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Monitor: pops expected reads and compares what the design returns
  initial begin
    forever begin
      sb_item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      mon_busy = 1'b1;
      rd_addr = it.addr;
      #1;
      n_checks++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=0x%03h actual=%0d expected=%0d", it.tag, it.addr, rd_data, it.exp);
      end
      mon_busy = 1'b0;
    end
  end

  task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Lets the monitor drain, then realigns on the next falling edge (one cycle)
  task automatic sync_checks();
    wait (sb_q.size() == 0 && !mon_busy);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic burst(input logic [NM-1:0] v, input logic [NM*BW-1:0] b, input int n);
    for (int k = 0; k < n; k++) begin
      beat_valid = v; beat_bytes = b;
      @(negedge clk);
    end
    beat_valid = '0; beat_bytes = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] ctr(input int slot);
    return AW'('hA0 + 4 * slot);
  endfunction

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd(12'h000, 0, "R1 prescaler");
    expect_rd(12'h004, 0, "R1 config");
    expect_rd(ctr(0), 0, "R1 master0");
    expect_rd(ctr(5), 0, "R1 total");
    sync_checks();

    // Tick every 2 cycles, window of 4 ticks = 8 cycles, bytes, enabled
    reg_wr(12'h000, 32'd1);
    reg_wr(12'h004, 32'h0003_0001);
    // Samples start at enabled cycle 1; window k covers cycles 8k-7..8k
    burst(4'b0011, {8'd0, 8'd0, 8'd4, 8'd16}, 4);       // cycles 1..4 -> 80
    idle(8);                                            // 5..12
    burst(4'hF, {4{8'd20}}, 8);                         // 13..20 spans windows 2/3
    idle(11);                                           // 21..31
    expect_rd(ctr(5), 320, "R5 straddling burst split");
    expect_rd(ctr(0), 224, "R3 master0 running sum");
    expect_rd(12'h004, 32'h0003_0001, "R10 config readback");
    expect_rd(12'h000, 32'd1, "R10 prescaler readback");
    sync_checks();                                      // 32
    burst(4'hF, {4{8'd20}}, 8);                         // 33..40 = window 5 -> 640
    idle(2);
    burst(4'b0100, {8'd0, 8'd50, 8'd0, 8'd0}, 2);       // window 6 -> 100
    idle(10);
    expect_rd(ctr(5), 640, "R4 peak of single window");
    expect_rd(ctr(0), 384, "R3 master0");
    expect_rd(ctr(1), 336, "R3 master1");
    expect_rd(ctr(2), 420, "R3 master2");
    expect_rd(ctr(3), 320, "R3 master3");
    sync_checks();

    // R8 disabled: beats ignored
    reg_wr(12'h004, 32'h0003_0000);
    burst(4'hF, {4{8'd20}}, 4);
    idle(2);
    expect_rd(ctr(0), 384, "R8 master0 holds");
    expect_rd(ctr(5), 640, "R8 total holds");
    sync_checks();

    // R7 re-enable clears; unit KiB
    reg_wr(12'h004, 32'h0003_0003);
    expect_rd(ctr(0), 0, "R7 master0 cleared");
    expect_rd(ctr(5), 0, "R7 total cleared");
    sync_checks();
    burst(4'b0001, {24'd0, 8'd255}, 8);                 // 2040 bytes
    idle(1);
    expect_rd(ctr(0), 1, "R6 KiB view");
    sync_checks();
    burst(4'b0001, {24'd0, 8'd255}, 8);                 // 4080 bytes
    idle(1);
    expect_rd(ctr(0), 3, "R6 fraction carried");
    sync_checks();
    reg_wr(12'h004, 32'h0003_0001);
    expect_rd(ctr(0), 4080, "R7 no clear while enabled");
    sync_checks();

    burst(4'hF, {4{8'd255}}, 4200);
    idle(10);
    expect_rd(ctr(0), 1075080, "R3 master0 large");
    sync_checks();
    reg_wr(12'h004, 32'h0003_0005);
    expect_rd(ctr(1), 1, "R6 MiB view");
    sync_checks();
    reg_wr(12'h004, 32'h0003_0003);
    expect_rd(ctr(1), 1045, "R6 KiB view master1");
    expect_rd(ctr(5), 7, "R4 total in KiB");
    sync_checks();

    burst(4'hF, {4{8'd255}}, 4200);
    idle(10);
    reg_wr(12'h004, 32'h0003_0001);
    expect_rd(ctr(1), SAT, "R9 master1 saturated");
    expect_rd(ctr(3), SAT, "R9 master3 saturated");
    expect_rd(ctr(5), 8160, "R4 total bytes");
    sync_checks();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule